// File: doc/BRIEF.md
# I2C Target Dual Address Matcher

This block decides whether an I2C transfer seen on the bus is addressed to this target. A bit-level front end hands it each received byte together with a marker telling whether that byte directly follows a START or repeated START. The block compares that address phase against two own-address slots that software programs. The first slot holds either a 7-bit or a 10-bit address. The second slot holds a 7-bit address only, and a mask field can make its low bits don't-care.

On a match the block acknowledges the address byte and latches a status word. The status word holds the 7-bit address code that matched and the transfer direction. The block also raises a sticky address flag, and it stretches SCL for as long as that flag stays set. Software clears the flag by writing a one to bit 3 of the clear port. When neither slot matches, the ACK line stays released.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: After reset, `status_o`, `own1_o` and `own2_o` are zero, and `ack_o` and `stretch_o` are low.
- R2: The slot 1 register keeps only bit 15 (enable), bit 10 (mode, 1 = 10-bit) and bits 9:0. The slot 2 register keeps only bit 15 (enable), bits 10:8 (mask) and bits 7:1 (address). All other bits read back as 0.
- R3: A first byte {a[6:0], rw} that matches slot 1 has these effects when slot 1 is enabled in 7-bit mode with bits 7:1 equal to a:
  - `ack_o` is high in the cycle after the byte.
  - The status word gets bits 23:17 = a, bit 16 = rw (1 = controller reads) and bit 3 = 1.
- R4: Slot 2 compares only the address bits above its mask value m:
  - For m from 0 to 6, address bits [m-1:0] are ignored (none are ignored for m = 0).
  - For m = 7, any address that is not reserved matches.
- R5: Slot 2 never matches a reserved address, meaning one whose top four bits are 0000 or 1111.
- R6: A 10-bit write match works as follows:
  - A first byte with header 11110XY, rw = 0 and XY equal to slot 1 bits 9:8 is acknowledged without setting the flag.
  - A next byte equal to slot 1 bits 7:0 is then acknowledged and sets the flag, with code 11110XY and direction 0.
  - A wrong second byte is not acknowledged.
- R7: A header with rw = 1 matches only after a full 10-bit match in the same transfer, and it then reports direction 1. A STOP clears that history.
- R8: A slot whose enable bit is 0 matches nothing. Its other bits read back unchanged.
- R9: A non-matching address leaves `ack_o` low and leaves the status word unchanged.
- R10: `stretch_o` follows the address flag. Writing the clear port with bit 3 set drops the flag. A write with bit 3 clear does not drop it. The code and direction fields are kept.
- R11: While the flag is set, incoming bytes are ignored: there is no ACK and no status change.
- R12: A byte that is not a first byte, arriving outside a pending 10-bit match, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own1_we_i | input | 1 | Write strobe for slot 1 |
| own2_we_i | input | 1 | Write strobe for slot 2 |
| reg_wdata_i | input | 16 | Write data for the slot registers |
| icr_we_i | input | 1 | Write strobe for the clear port |
| icr_wdata_i | input | 16 | Clear data; bit 3 clears the address flag |
| byte_valid_i | input | 1 | A received byte is present this cycle |
| byte_first_i | input | 1 | The byte directly follows a START or repeated START |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | STOP detected on the bus |
| ack_o | output | 1 | Drive ACK for the byte of the previous cycle |
| stretch_o | output | 1 | Hold SCL low |
| status_o | output | 32 | Bits 23:17 code, bit 16 direction, bit 3 flag |
| own1_o | output | 16 | Slot 1 readback |
| own2_o | output | 16 | Slot 2 readback |

## Verification
The assertions check on every cycle that the flag is sticky until a clear write, that a clear write drops it, and that code and direction stay frozen while the flag is set. They also check that every ACK follows a received byte, that an ACK without the flag only answers a 10-bit header, and that the reserved register bits stay zero. Only the bench scenarios can show which address values actually match. That covers the mask widths, reserved codes, disabled slots, the 10-bit two-byte sequence, and the repeated-start read that depends on history cleared by STOP.

// File: rtl/i2c_tam_pkg.sv
package i2c_tam_pkg;
  localparam int REG_W    = 16;
  localparam int STAT_W   = 32;
  localparam int A7_W     = 7;
  localparam int EN_BIT   = 15;
  localparam int MODE_BIT = 10;
  localparam int FLAG_BIT = 3;
  localparam int DIR_BIT  = 16;
  localparam int CODE_LSB = 17;
  localparam logic [4:0] HDR10 = 5'b11110;
  localparam logic [REG_W-1:0] OWN1_KEEP = 16'h87FF;
  localparam logic [REG_W-1:0] OWN2_KEEP = 16'h87FE;

  function automatic logic is_reserved(input logic [A7_W-1:0] a);
    return (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
  endfunction

  function automatic logic [A7_W-1:0] care_mask(input logic [2:0] m);
    return (m == 3'd7) ? '0 : A7_W'(7'h7F << m);
  endfunction
endpackage

// File: rtl/i2c_tam_regs.sv
module i2c_tam_regs
  import i2c_tam_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             own1_we_i,
  input  logic             own2_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] own1_o,
  output logic [REG_W-1:0] own2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own1_o <= '0;
      own2_o <= '0;
    end else begin
      if (own1_we_i) own1_o <= wdata_i & OWN1_KEEP;
      if (own2_we_i) own2_o <= wdata_i & OWN2_KEEP;
    end
  end
endmodule

// File: rtl/i2c_tam_cmp.sv
module i2c_tam_cmp
  import i2c_tam_pkg::*;
(
  input  logic [REG_W-1:0] own1_i,
  input  logic [REG_W-1:0] own2_i,
  input  logic [7:0]       byte_i,
  output logic             hit7_o,
  output logic             hdr_hit_o,
  output logic             lo_hit_o
);
  logic [A7_W-1:0] a7, care;
  logic s1_7, s2_7;

  assign a7   = byte_i[7:1];
  assign care = care_mask(own2_i[10:8]);

  assign s1_7 = own1_i[EN_BIT] && !own1_i[MODE_BIT] && (a7 == own1_i[7:1]);
  assign s2_7 = own2_i[EN_BIT] && !is_reserved(a7) &&
                (((a7 ^ own2_i[7:1]) & care) == '0);
  assign hit7_o = s1_7 || s2_7;

  // 10-bit header: 11110 + address bits 9:8
  assign hdr_hit_o = own1_i[EN_BIT] && own1_i[MODE_BIT] &&
                     (a7 == {HDR10, own1_i[9:8]});
  assign lo_hit_o  = own1_i[EN_BIT] && own1_i[MODE_BIT] &&
                     (byte_i == own1_i[7:0]);
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tam_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own1_we_i,
  input  logic              own2_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              icr_we_i,
  input  logic [REG_W-1:0]  icr_wdata_i,
  input  logic              byte_valid_i,
  input  logic              byte_first_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  output logic              ack_o,
  output logic              stretch_o,
  output logic [STAT_W-1:0] status_o,
  output logic [REG_W-1:0]  own1_o,
  output logic [REG_W-1:0]  own2_o
);
  logic hit7, hdr_hit, lo_hit;
  logic flag_q, dir_q, wait10_q, ten_done_q, ack_q;
  logic [A7_W-1:0] code_q;
  logic evt, is_hdr, rw, clr;

  i2c_tam_regs u_regs (
    .clk_i, .rst_ni, .own1_we_i, .own2_we_i,
    .wdata_i(reg_wdata_i), .own1_o, .own2_o
  );

  i2c_tam_cmp u_cmp (
    .own1_i(own1_o), .own2_i(own2_o), .byte_i,
    .hit7_o(hit7), .hdr_hit_o(hdr_hit), .lo_hit_o(lo_hit)
  );

  assign evt    = byte_valid_i && !flag_q && !stop_i;
  assign is_hdr = byte_i[7:3] == HDR10;
  assign rw     = byte_i[0];
  assign clr    = icr_we_i && icr_wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= 1'b0;
      dir_q      <= 1'b0;
      code_q     <= '0;
      wait10_q   <= 1'b0;
      ten_done_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (clr) flag_q <= 1'b0;
      if (stop_i) begin
        wait10_q   <= 1'b0;
        ten_done_q <= 1'b0;
      end else if (evt && byte_first_i) begin
        wait10_q <= 1'b0;
        if (is_hdr) begin
          if (hdr_hit && !rw) begin
            ack_q      <= 1'b1;
            wait10_q   <= 1'b1;
            ten_done_q <= 1'b0;
          end else if (hdr_hit && rw && ten_done_q) begin
            ack_q  <= 1'b1;
            flag_q <= 1'b1;
            code_q <= byte_i[7:1];
            dir_q  <= 1'b1;
          end
        end else begin
          ten_done_q <= 1'b0;
          if (hit7) begin
            ack_q  <= 1'b1;
            flag_q <= 1'b1;
            code_q <= byte_i[7:1];
            dir_q  <= rw;
          end
        end
      end else if (evt && wait10_q) begin
        wait10_q <= 1'b0;
        if (lo_hit) begin
          ack_q      <= 1'b1;
          flag_q     <= 1'b1;
          code_q     <= {HDR10, own1_o[9:8]};
          dir_q      <= 1'b0;
          ten_done_q <= 1'b1;
        end
      end
    end
  end

  assign ack_o     = ack_q;
  assign stretch_o = flag_q;

  always_comb begin
    status_o = '0;
    status_o[CODE_LSB +: A7_W] = code_q;
    status_o[DIR_BIT]          = dir_q;
    status_o[FLAG_BIT]         = flag_q;
  end
endmodule

// File: rtl/i2c_tgt_addr_match_chk.sv
module i2c_tgt_addr_match_chk
  import i2c_tam_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic [7:0]        byte_i,
  input logic              icr_we_i,
  input logic [REG_W-1:0]  icr_wdata_i,
  input logic              ack_o,
  input logic              stretch_o,
  input logic [STAT_W-1:0] status_o,
  input logic [REG_W-1:0]  own1_o,
  input logic [REG_W-1:0]  own2_o
);
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLAG_BIT] && !(icr_we_i && icr_wdata_i[FLAG_BIT]) |=> status_o[FLAG_BIT]); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLAG_BIT] && icr_we_i && icr_wdata_i[FLAG_BIT] |=> !status_o[FLAG_BIT]); // R10
  AST_STRETCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o == status_o[FLAG_BIT]); // R10
  AST_STATUS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLAG_BIT] |=> $stable(status_o[23:16])); // R11
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_valid_i)); // R3
  AST_FLAG_RISE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[FLAG_BIT]) |-> ack_o); // R3
  AST_HDR_ONLY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !status_o[FLAG_BIT] |-> $past(byte_i[7:3]) == HDR10); // R6
  AST_REG_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own1_o & ~OWN1_KEEP) == '0 && (own2_o & ~OWN2_KEEP) == '0); // R2
endmodule

bind i2c_tgt_addr_match i2c_tgt_addr_match_chk u_chk (
  .clk_i, .rst_ni, .byte_valid_i, .byte_i, .icr_we_i, .icr_wdata_i,
  .ack_o, .stretch_o, .status_o, .own1_o, .own2_o
);

// File: tb/i2c_tgt_addr_match_bench.sv
module i2c_tgt_addr_match_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic own1_we = 0, own2_we = 0, icr_we = 0;
  logic [15:0] reg_wdata = 0, icr_wdata = 0;
  logic byte_valid = 0, byte_first = 0, stop = 0;
  logic [7:0] byte_d = 0;
  logic ack, stretch;
  logic [31:0] status;
  logic [15:0] own1, own2;
  int checks = 0, errors = 0;
  logic [15:0] m1, m2;

  always #5 clk = ~clk;

  i2c_tgt_addr_match u_i2c_tgt_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .own1_we_i(own1_we), .own2_we_i(own2_we),
    .reg_wdata_i(reg_wdata), .icr_we_i(icr_we), .icr_wdata_i(icr_wdata),
    .byte_valid_i(byte_valid), .byte_first_i(byte_first), .byte_i(byte_d),
    .stop_i(stop), .ack_o(ack), .stretch_o(stretch), .status_o(status),
    .own1_o(own1), .own2_o(own2)
  );

  function automatic logic [31:0] st(input logic [6:0] c, input logic d, input logic f);
    return (32'(c) << 17) | (32'(d) << 16) | (32'(f) << 3);
  endfunction

  function automatic logic exp7(input logic [6:0] a);
    logic s1, s2, res;
    logic [6:0] care;
    s1 = m1[15] && !m1[10] && (a == m1[7:1]);
    res = (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
    care = (m2[10:8] == 3'd7) ? 7'h0 : 7'(7'h7F << m2[10:8]);
    s2 = m2[15] && !res && (((a ^ m2[7:1]) & care) == 7'h0);
    return s1 || s2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic which, input logic [15:0] d);
    @(negedge clk);
    if (which) own2_we = 1; else own1_we = 1;
    reg_wdata = d;
    if (which) m2 = d & 16'h87FE; else m1 = d & 16'h87FF;
    @(negedge clk);
    own1_we = 0; own2_we = 0;
  endtask

  task automatic send(input logic first, input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1; byte_first = first; byte_d = b;
    @(negedge clk);
    byte_valid = 0; byte_first = 0;
  endtask

  task automatic clr(input logic [15:0] d);
    @(negedge clk);
    icr_we = 1; icr_wdata = d;
    @(negedge clk);
    icr_we = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    m1 = 0; m2 = 0;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", status, 0); chk("R1 ack", 32'(ack), 0);
    chk("R1 stretch", 32'(stretch), 0); chk("R1 own1", 32'(own1), 0);
    chk("R1 own2", 32'(own2), 0);
    rst_n = 1;
    // R2
    wr(0, 16'hFFFF); chk("R2 own1", 32'(own1), 32'h87FF);
    wr(1, 16'hFFFF); chk("R2 own2", 32'(own2), 32'h87FE);
    // R3
    wr(0, 16'h8000 | (16'h3C << 1)); wr(1, 16'h0000);
    send(1, {7'h3C, 1'b1});
    chk("R3 ack", 32'(ack), 1); chk("R3 status", status, st(7'h3C, 1, 1));
    chk("R10 stretch set", 32'(stretch), 1);
    // R11
    send(1, {7'h3C, 1'b0});
    chk("R11 no ack", 32'(ack), 0); chk("R11 status", status, st(7'h3C, 1, 1));
    // R10
    clr(16'h0004); chk("R10 other bit", status, st(7'h3C, 1, 1));
    clr(16'h0008); chk("R10 cleared", status, st(7'h3C, 1, 0));
    chk("R10 stretch off", 32'(stretch), 0);
    // R9
    send(1, {7'h28, 1'b0});
    chk("R9 no ack", 32'(ack), 0); chk("R9 status", status, st(7'h3C, 1, 0));
    // R8
    wr(0, 16'h0078); chk("R8 readback", 32'(own1), 32'h0078);
    send(1, 8'h78); chk("R8 disabled", 32'(ack), 0);
    // R4
    wr(1, 16'h8248);
    send(1, {7'h27, 1'b0}); chk("R4 low bits ignored", 32'(ack), 1);
    chk("R4 status", status, st(7'h27, 0, 1)); clr(16'h0008);
    send(1, {7'h2C, 1'b0}); chk("R4 high bit compared", 32'(ack), 0);
    wr(1, 16'h8700);
    send(1, {7'h55, 1'b1}); chk("R4 mask7 any", 32'(ack), 1); clr(16'h0008);
    // R5
    send(1, {7'h03, 1'b0}); chk("R5 reserved low", 32'(ack), 0);
    wr(1, 16'h80F8);
    send(1, {7'h7C, 1'b0}); chk("R5 reserved own", 32'(ack), 0);
    // R6
    wr(1, 16'h0000); wr(0, 16'h86A5);
    send(1, 8'hF4); chk("R6 header ack", 32'(ack), 1);
    chk("R6 no flag yet", 32'(status[3]), 0);
    send(0, 8'hA5); chk("R6 second ack", 32'(ack), 1);
    chk("R6 status", status, st(7'h7A, 0, 1)); clr(16'h0008);
    // R7
    send(1, 8'hF5); chk("R7 rstart read ack", 32'(ack), 1);
    chk("R7 status", status, st(7'h7A, 1, 1)); clr(16'h0008);
    do_stop();
    send(1, 8'hF5); chk("R7 after stop", 32'(ack), 0);
    send(1, 8'hF4); send(0, 8'hA4);
    chk("R6 wrong second", 32'(ack), 0); chk("R6 no flag", 32'(status[3]), 0);
    send(0, 8'hA5); chk("R12 data ignored", 32'(ack), 0);
    send(1, 8'hF0); chk("R6 wrong XY", 32'(ack), 0);
    // random: R3 R4 R5
    for (int i = 0; i < 300; i++) begin
      logic [6:0] a, o;
      logic r, e;
      if (i % 20 == 0) begin
        o = 7'($urandom_range(8, 119));
        wr(0, {($urandom_range(0, 3) != 0), 5'b0, 2'b0, o, 1'b0});
        wr(1, {($urandom_range(0, 3) != 0), 4'b0, 3'($urandom()), 7'($urandom()), 1'b0});
      end
      a = 7'($urandom());
      if (a[6:2] == 5'b11110) a[6] = 1'b0;
      if (i % 4 == 0) a = m1[7:1];
      r = 1'($urandom());
      e = exp7(a);
      prev = status;
      send(1, {a, r});
      chk("R4 random ack", 32'(ack), 32'(e));
      chk("R3 random status", status, e ? st(a, r, 1) : (prev & ~32'h8));
      if (e) clr(16'h0008);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule